// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns eight asynchronous interrupt pins into eight per-pin interrupt requests. Each pin has its own 2-bit sense mode, which selects low level, any edge, falling edge or rising edge. Every pin is brought into the clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample from the previous cycle.

Edge events latch into a per-pin flag. The flag is set even while the pin's mask bit is clear, so software can clear an event before it enables the pin. A low-level request is not latched: it follows the synchronized pin directly. Every request is gated by the pin's mask bit and by one global enable input.

Software reaches four 8-bit registers over a small read/write bus. Two registers hold the sense modes, one holds the mask and one holds the flags. Flags are cleared by writing ones to the flag register, or by a per-pin acknowledge input that models the automatic clear when the interrupt is serviced.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read 0 and every request output is 0, so every pin starts in low-level mode.
- R2: The address map is: 0 = sense modes for pins 0–3, 1 = sense modes for pins 4–7, 2 = mask, 3 = flags. The mode of pin n sits at bits [2n+1:2n] of register 0 for n < 4, and at bits [2(n−4)+1:2(n−4)] of register 1 for n ≥ 4. All registers read back what was written. Read data appears on the clock edge that samples the read strobe.
- R3: In mode 00 (low level), request n is 1 while the synchronized pin is low and mask n and the global enable are set, and no flag is latched. The request follows the pin three clock edges after the pin changes.
- R4: In mode 01 (any edge), both a falling and a rising edge on pin n set flag n.
- R5: In mode 10 (falling edge), a falling edge sets flag n and a rising edge does not.
- R6: In mode 11 (rising edge), a rising edge sets flag n and a falling edge does not.
- R7: In an edge mode, request n is 1 exactly when flag n, mask n and the global enable are all 1 (registered one cycle). Flags are set even while mask n is 0.
- R8: Writing to the flag register clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: A one-cycle pulse on acknowledge bit n clears flag n.
- R10: When an edge is detected in the same cycle as a clear of the same flag (by write or by acknowledge), the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| global_en | input | 1 | Global interrupt enable |
| irq_pin | input | 8 | Asynchronous interrupt pins |
| irq_ack | input | 8 | Per-pin service acknowledge; clears the flag |
| irq_req | output | 8 | Per-pin registered interrupt request |

## Verification
The two functions that can fall in the same cycle are the setting of a flag by a freshly detected edge and the clearing of that flag, either by a write-one to the flag register or by an acknowledge pulse. The bench changes a pin, counts the two synchronizer edges, and then drives the clear so that it is sampled on the same edge at which the detector fires. It then reads the flag register and expects the bit to still be set. A plain clear that follows, with no edge, must then remove the bit, which shows that the clear path itself works.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SENSE_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SENSE_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS    = 2'd3;

endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  // Reset to the idle-high level so leaving reset creates no false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/irqs_detect.sv
module irqs_detect
  import irqs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   pin_s,
  input  logic [2*W-1:0] mode_bus,
  output logic [W-1:0]   hit,
  output logic [W-1:0]   level_act
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= pin_s;
  end

  for (genvar n = 0; n < W; n++) begin : g_det
    sense_t mode_n;
    assign mode_n = sense_t'(mode_bus[2*n +: 2]);

    always_comb begin
      unique case (mode_n)
        SENSE_ANY:  hit[n] = pin_s[n] ^ prev_q[n];
        SENSE_FALL: hit[n] = prev_q[n] & ~pin_s[n];
        SENSE_RISE: hit[n] = ~prev_q[n] & pin_s[n];
        default:    hit[n] = 1'b0;
      endcase
    end

    assign level_act[n] = (mode_n == SENSE_LOW) & ~pin_s[n];
  end

endmodule

// File: rtl/irqs_regs.sv
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     hit,
  input  logic [DW-1:0]     ack,
  output logic [2*DW-1:0]   mode_bus,
  output logic [DW-1:0]     mask_q,
  output logic [DW-1:0]     flag_q
);

  logic [DW-1:0] sense_lo_q;
  logic [DW-1:0] sense_hi_q;
  logic [DW-1:0] clr;
  logic          flag_wr;

  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAGS);
  assign clr     = (flag_wr ? bus_wdata : '0) | ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      mask_q     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_SENSE_LO: sense_lo_q <= bus_wdata;
        ADDR_SENSE_HI: sense_hi_q <= bus_wdata;
        ADDR_MASK:     mask_q     <= bus_wdata;
        default:       ;
      endcase
    end
  end

  // A new edge outranks any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_SENSE_LO: bus_rdata <= sense_lo_q;
        ADDR_SENSE_HI: bus_rdata <= sense_hi_q;
        ADDR_MASK:     bus_rdata <= mask_q;
        default:       bus_rdata <= flag_q;
      endcase
    end
  end

  assign mode_bus = {sense_hi_q, sense_lo_q};

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import irqs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              global_en,
  input  logic [DW-1:0]     irq_pin,
  input  logic [DW-1:0]     irq_ack,
  output logic [DW-1:0]     irq_req
);

  localparam int NUM_IN = DW;

  logic [NUM_IN-1:0]   pin_s;
  logic [NUM_IN-1:0]   edge_hit;
  logic [NUM_IN-1:0]   level_act;
  logic [2*NUM_IN-1:0] mode_bus;
  logic [NUM_IN-1:0]   mask_q;
  logic [NUM_IN-1:0]   flag_q;

  irqs_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_pin),
    .q_sync  (pin_s)
  );

  irqs_detect #(.W(NUM_IN)) u_det (
    .clk       (clk),
    .rst       (rst),
    .pin_s     (pin_s),
    .mode_bus  (mode_bus),
    .hit       (edge_hit),
    .level_act (level_act)
  );

  irqs_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hit       (edge_hit),
    .ack       (irq_ack),
    .mode_bus  (mode_bus),
    .mask_q    (mask_q),
    .flag_q    (flag_q)
  );

  for (genvar n = 0; n < NUM_IN; n++) begin : g_req
    logic is_level;
    assign is_level = (sense_t'(mode_bus[2*n +: 2]) == SENSE_LOW);

    always_ff @(posedge clk) begin
      if (rst)
        irq_req[n] <= 1'b0;
      else
        irq_req[n] <= (is_level ? level_act[n] : flag_q[n]) & mask_q[n] & global_en;
    end
  end

endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic         global_en,
  input logic [W-1:0] irq_req,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] edge_hit
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && flag_q == '0)); // R1

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> $past(global_en)); // R7

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    (irq_req & ~$past(mask_q)) == '0); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=>
      ((flag_q & $past(bus_wdata) & ~$past(edge_hit)) == '0)); // R8

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit))); // R10

endmodule

bind ext_irq_sense irqs_checker #(.W(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .global_en (global_en),
  .irq_req   (irq_req),
  .mask_q    (mask_q),
  .flag_q    (flag_q),
  .edge_hit  (edge_hit)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/100ps
module ext_irq_sense_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       global_en = 1'b0;
  logic [7:0] irq_pin = 8'hFF;
  logic [7:0] irq_ack = '0;
  logic [7:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .global_en(global_en), .irq_pin(irq_pin), .irq_ack(irq_ack),
    .irq_req(irq_req)
  );

  // Monitor: the read strobe seen at a rising edge yields data by the next falling edge.
  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read data %02h with nothing expected", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: read actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_req(input logic [7:0] e, input string t);
    checks++;
    if (irq_req !== e) begin
      errors++;
      $display("FAIL %s: request actual %02h expected %02h", t, irq_req, e);
    end
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    irq_pin[i] = v;
    repeat (4) @(negedge clk);
  endtask

  // Edge on pin i timed so that the detector fires on the edge that samples the clear.
  task automatic edge_with_clear(input int i, input bit use_ack);
    @(negedge clk);
    irq_pin[i] = ~irq_pin[i];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (use_ack) irq_ack[i] = 1'b1;
    else begin bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01 << i; end
    @(negedge clk);
    irq_ack = '0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_req(8'h00, "R1 during reset");
    rst = 1'b0;
    // R1 reset values
    bus_read(2'd0, 8'h00, "R1 sense lo");
    bus_read(2'd1, 8'h00, "R1 sense hi");
    bus_read(2'd2, 8'h00, "R1 mask");
    bus_read(2'd3, 8'h00, "R1 flags");
    check_req(8'h00, "R1 requests");

    // R2 layout: pin0 rise, pin1 fall, pin2 any, pin3 level; pin5 rise in high register
    bus_write(2'd0, 8'h1B);
    bus_write(2'd1, 8'h0C);
    bus_write(2'd2, 8'h00);
    bus_read(2'd0, 8'h1B, "R2 sense lo readback");
    bus_read(2'd1, 8'h0C, "R2 sense hi readback");
    bus_read(2'd2, 8'h00, "R2 mask readback");
    global_en = 1'b1;

    // R3 level mode on pin3
    bus_write(2'd2, 8'h08);
    set_pin(3, 1'b0);
    check_req(8'h08, "R3 level low asserts");
    bus_read(2'd3, 8'h00, "R3 level latches no flag");
    set_pin(3, 1'b1);
    check_req(8'h00, "R3 level released");

    // R6 rising mode on pin0
    set_pin(0, 1'b0);
    bus_read(2'd3, 8'h00, "R6 falling ignored");
    set_pin(0, 1'b1);
    bus_read(2'd3, 8'h01, "R6 rising sets");
    // R5 falling mode on pin1
    set_pin(1, 1'b0);
    bus_read(2'd3, 8'h03, "R5 falling sets");
    set_pin(1, 1'b1);
    bus_read(2'd3, 8'h03, "R5 rising ignored");
    // R4 any edge on pin2
    set_pin(2, 1'b0);
    bus_read(2'd3, 8'h07, "R4 fall sets");
    bus_write(2'd3, 8'h04);
    bus_read(2'd3, 8'h03, "R8 write one clears");
    set_pin(2, 1'b1);
    bus_read(2'd3, 8'h07, "R4 rise sets");
    // R2 high register field for pin5
    set_pin(5, 1'b0);
    set_pin(5, 1'b1);
    bus_read(2'd3, 8'h27, "R2 pin5 mode in high register");

    // R7 gating
    check_req(8'h00, "R7 masked flags give no request");
    bus_write(2'd2, 8'h25);
    repeat (2) @(negedge clk);
    check_req(8'h25, "R7 unmasked flags request");
    global_en = 1'b0;
    repeat (2) @(negedge clk);
    check_req(8'h00, "R7 global enable off");
    global_en = 1'b1;
    repeat (2) @(negedge clk);
    check_req(8'h25, "R7 global enable on");

    // R8 write-one-to-clear
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, 8'h27, "R8 zero write no effect");
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, 8'h25, "R8 clears selected bit");

    // R9 acknowledge
    @(negedge clk); irq_ack = 8'h01;
    @(negedge clk); irq_ack = 8'h00;
    repeat (2) @(negedge clk);
    check_req(8'h24, "R9 request drops after ack");
    bus_read(2'd3, 8'h24, "R9 ack clears flag");

    // R10 edge against write clear (pin2 any edge, flag already set)
    edge_with_clear(2, 1'b0);
    bus_read(2'd3, 8'h24, "R10 edge beats write clear");
    bus_write(2'd3, 8'h04);
    bus_read(2'd3, 8'h20, "R10 plain write clear");
    // R10 edge against acknowledge (pin5 rising)
    set_pin(5, 1'b0);
    edge_with_clear(5, 1'b1);
    bus_read(2'd3, 8'h20, "R10 edge beats ack");
    @(negedge clk); irq_ack = 8'h20;
    @(negedge clk); irq_ack = 8'h00;
    bus_read(2'd3, 8'h00, "R9 ack alone clears");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule